// File: doc/BRIEF.md
# Base-plus-delta cache line decompressor

This block rebuilds a full 32-byte cache line from its compressed form. It sits on the hit path of a compressed cache, between the data array and the requester. Each request carries three things: a 4-bit encoding code, a per-element select mask, and the stored bytes, packed from byte 0 upward.

For the base-plus-delta encodings, the block handles every element of the line at once, with one adder per element. Each adder takes the element's narrow delta, sign-extends it to the element width, and adds either the stored base or zero, as the element's mask bit selects. The zero-line encoding and the repeated-value encoding are expanded directly, without adders. An uncompressed line passes through unchanged. The result is registered, so every encoding has the same one-cycle latency.

Top module: `bdi_decompress`

## Requirements
- R1: `out_valid` rises exactly one clock after `in_valid`, for every code. While `rst` is high, and at the first edge after it, `out_valid` and `out_line` are both zero.
- R2: Code 0 gives an all-zero line, whatever the mask and data inputs hold.
- R3: Code 1 copies input bytes 0..7 into each of the four 8-byte quarters of the output.
- R4: Code 15 copies all 32 input bytes to the output unchanged. Any unassigned code (8 to 14) behaves the same way.
- R5: In the base-plus-delta layout, the base occupies the lowest B input bytes, little-endian. The delta of element e starts at input byte B + e*D, where D is the delta size. Element e is written to output bytes e*B through e*B+B-1, and there are 32/B elements.
- R6: Each delta is sign-extended to B bytes. When mask bit e is 1, the base is added to it. When mask bit e is 0, element e is the sign-extended delta alone, because its base is an implicit zero.
- R7: The sum wraps modulo 2^(8*B) and carries nothing into the next element.
- R8: Codes 2, 3, 4, 5, 6 and 7 select base/delta byte sizes 8/1, 8/2, 8/4, 4/1, 4/2 and 2/1, in that order.
- R9: While `in_valid` is low, `out_line` holds its last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed line present this cycle |
| in_code | input | 4 | Encoding code |
| in_mask | input | 16 | Per-element select: 1 adds the base, 0 adds zero |
| in_data | input | 256 | Stored bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Rebuilt line valid |
| out_line | output | 256 | Rebuilt line, byte 0 in bits 7:0 |

## Verification
Every piece of state in the block reaches the ports on the next clock. A wrong lane width, a missing sign extension, a dropped carry or a swapped mask bit therefore corrupts specific output bytes in the very cycle after the request. A mis-routed code shows up the same way, as a wrong line. The scoreboard compares every returned line against an independent byte-level model, so the first such error is reported at once. A broken hold or valid register shows up on the first idle cycle or the first request.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

  typedef enum logic [3:0] {
    CODE_ZERO = 4'd0,
    CODE_REP  = 4'd1,
    CODE_B8D1 = 4'd2,
    CODE_B8D2 = 4'd3,
    CODE_B8D4 = 4'd4,
    CODE_B4D1 = 4'd5,
    CODE_B4D2 = 4'd6,
    CODE_B2D1 = 4'd7,
    CODE_RAW  = 4'd15
  } bdi_code_e;

  localparam int NUM_BD   = 6;
  localparam int FIRST_BD = 2;
  localparam int REP_BYTES = 8;

  // Base size in bytes for base/delta variant k (code FIRST_BD+k)
  function automatic int bd_base_bytes(input int k);
    case (k)
      0, 1, 2: return 8;
      3, 4:    return 4;
      default: return 2;
    endcase
  endfunction

  // Delta size in bytes for base/delta variant k
  function automatic int bd_delta_bytes(input int k);
    case (k)
      0, 3, 5: return 1;
      1, 4:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/bdi_bd_unit.sv
module bdi_bd_unit #(
  parameter int LINE_BYTES = 32,
  parameter int BASE_B     = 8,
  parameter int DELTA_B    = 1,
  localparam int NELEM     = LINE_BYTES / BASE_B,
  localparam int EW        = BASE_B * 8,
  localparam int DW        = DELTA_B * 8,
  localparam int PW        = (BASE_B + NELEM * DELTA_B) * 8
) (
  input  logic [PW-1:0]           packed_i,
  input  logic [NELEM-1:0]        sel_i,
  output logic [LINE_BYTES*8-1:0] line_o
);

  logic [EW-1:0] base;
  assign base = packed_i[EW-1:0];

  generate
    for (genvar e = 0; e < NELEM; e++) begin : g_lane
      logic [DW-1:0] delta;
      logic [EW-1:0] delta_ext;
      logic [EW-1:0] addend;
      assign delta     = packed_i[EW + e*DW +: DW];
      assign delta_ext = {{(EW-DW){delta[DW-1]}}, delta};
      assign addend    = sel_i[e] ? base : '0;
      assign line_o[e*EW +: EW] = addend + delta_ext;
    end
  endgenerate

endmodule

// File: rtl/bdi_rep_unit.sv
module bdi_rep_unit #(
  parameter int LINE_BYTES = 32,
  parameter int REP_BYTES  = 8,
  localparam int COPIES    = LINE_BYTES / REP_BYTES,
  localparam int RW        = REP_BYTES * 8
) (
  input  logic [RW-1:0]           val_i,
  output logic [LINE_BYTES*8-1:0] line_o
);

  generate
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      assign line_o[c*RW +: RW] = val_i;
    end
  endgenerate

endmodule

// File: rtl/bdi_decompress.sv
module bdi_decompress
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  localparam int LW        = LINE_BYTES * 8,
  localparam int MASK_W    = LINE_BYTES / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_code,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [LW-1:0]     in_data,
  output logic              out_valid,
  output logic [LW-1:0]     out_line
);

  logic [LW-1:0] bd_line [NUM_BD];
  logic [LW-1:0] rep_line;
  logic [LW-1:0] next_line;

  generate
    for (genvar k = 0; k < NUM_BD; k++) begin : g_bd
      localparam int BB = bd_base_bytes(k);
      localparam int DB = bd_delta_bytes(k);
      localparam int NE = LINE_BYTES / BB;
      localparam int PW = (BB + NE * DB) * 8;
      bdi_bd_unit #(
        .LINE_BYTES(LINE_BYTES),
        .BASE_B    (BB),
        .DELTA_B   (DB)
      ) u_bd (
        .packed_i(in_data[PW-1:0]),
        .sel_i   (in_mask[NE-1:0]),
        .line_o  (bd_line[k])
      );
    end
  endgenerate

  bdi_rep_unit #(
    .LINE_BYTES(LINE_BYTES),
    .REP_BYTES (REP_BYTES)
  ) u_rep (
    .val_i (in_data[REP_BYTES*8-1:0]),
    .line_o(rep_line)
  );

  always_comb begin
    next_line = in_data;
    if (in_code == CODE_ZERO) next_line = '0;
    if (in_code == CODE_REP)  next_line = rep_line;
    for (int k = 0; k < NUM_BD; k++) begin
      if (in_code == 4'(FIRST_BD + k)) next_line = bd_line[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_line  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_line <= next_line;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_ZERO_LINE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == CODE_ZERO) |=> (out_line == '0)); // R2
  AST_REP_QUARTERS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == CODE_REP) |=>
      (out_line[LW-1 -: 64] == $past(in_data[63:0]))); // R3
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == CODE_RAW) |=> (out_line == $past(in_data))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_line)); // R9

endmodule

// File: tb/bdi_decompress_tb_top.sv
module bdi_decompress_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0;
  logic [3:0]   in_code  = '0;
  logic [15:0]  in_mask  = '0;
  logic [255:0] in_data  = '0;
  logic         out_valid;
  logic [255:0] out_line;

  bdi_decompress dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_mask(in_mask), .in_data(in_data),
    .out_valid(out_valid), .out_line(out_line)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit have_last = 0;
  logic [255:0] last_line;
  logic [255:0] exp_q[$];
  string        tag_q[$];

  function automatic logic [63:0] rd(input logic [255:0] d, input int off, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = d[(off+i)*8 +: 8];
    return v;
  endfunction

  function automatic logic [255:0] model(input logic [3:0] code, input logic [15:0] mask,
                                         input logic [255:0] data);
    logic [255:0] r = '0;
    logic [63:0] base, dv, sum;
    int b, dl;
    case (code)
      4'd0: return '0;
      4'd1: begin
        for (int i = 0; i < 4; i++) r[i*64 +: 64] = data[63:0];
        return r;
      end
      4'd2: begin b = 8; dl = 1; end
      4'd3: begin b = 8; dl = 2; end
      4'd4: begin b = 8; dl = 4; end
      4'd5: begin b = 4; dl = 1; end
      4'd6: begin b = 4; dl = 2; end
      4'd7: begin b = 2; dl = 1; end
      default: return data;
    endcase
    base = rd(data, 0, b);
    for (int e = 0; e < 32 / b; e++) begin
      dv = rd(data, b + e*dl, dl);
      if (dv[dl*8-1]) dv = dv | (~64'd0 << (dl*8));
      sum = (mask[e] ? base : 64'd0) + dv;
      for (int i = 0; i < b; i++) r[(e*b+i)*8 +: 8] = sum[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic send(input logic [3:0] code, input logic [15:0] mask,
                      input logic [255:0] data, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = code;
    in_mask  = mask;
    in_data  = data;
    exp_q.push_back(model(code, mask, data));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected out_valid: actual=1 expected=0");
        end else begin
          logic [255:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_line !== e) begin
            failures++;
            $display("FAIL %s line mismatch: actual=%h expected=%h", t, out_line, e);
          end
        end
        last_line = out_line;
        have_last = 1;
      end else if (have_last) begin
        checks++;
        if (out_line !== last_line) begin
          failures++;
          $display("FAIL R9 hold: actual=%h expected=%h", out_line, last_line);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [255:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_line !== '0) begin
      failures++;
      $display("FAIL R1 reset state: actual=%b/%h expected=0/0", out_valid, out_line);
    end
    rst = 1'b0;

    // R2: zero line ignores garbage data and mask
    send(4'd0, 16'hFFFF, {8{32'hDEADBEEF}}, "R2");
    // R3: repeated 8-byte value
    send(4'd1, 16'h0000, {24'hAAAAAA, 168'd0, 64'h0123456789ABCDEF}, "R3");
    // R4: raw, and unassigned code 11
    send(4'd15, 16'h1234, {8{32'h13579BDF}}, "R4");
    send(4'd11, 16'hFFFF, {16{16'hC3A5}}, "R4 unassigned");
    idle(2);

    // R5 R8: 8/1 pointer-like line, all bases used
    d = '0;
    d[63:0] = 64'h00000000C04039C0;
    d[64 +: 32] = 32'h38_10_08_00;
    send(4'd2, 16'h000F, d, "R5 R8 8/1");
    // R6: 8/2 alternating mask, negative deltas
    d = '0;
    d[63:0] = 64'h1000_0000_0000_0100;
    d[64 +: 64] = 64'hFFFE_0003_8000_7FFF;
    send(4'd3, 16'h0005, d, "R6 8/2");
    // R6: 8/4 all immediates
    d = '0;
    d[63:0] = 64'h5555_5555_5555_5555;
    d[64 +: 128] = 128'h8000_0000_0000_0001_FFFF_FFFF_1234_5678;
    send(4'd4, 16'h0000, d, "R6 8/4");
    // R7: 4/1 wrap of base 0xFFFFFFF0
    d = '0;
    d[31:0] = 32'hFFFF_FFF0;
    d[32 +: 64] = 64'h7F_80_01_FF_10_20_F0_00;
    send(4'd5, 16'h00FF, d, "R7 4/1");
    // R8: 4/2 mixed mask
    d = '0;
    d[31:0] = 32'h0001_8000;
    d[32 +: 128] = {8{16'h9ABC}} ^ 128'h0123_4567_89AB_CDEF_0000_FFFF_7FFF_8000;
    send(4'd6, 16'h0069, d, "R8 4/2");
    // R8: 2/1 sixteen lanes
    d = '0;
    d[15:0] = 16'hFF80;
    d[16 +: 128] = 128'h80_7F_01_FF_00_10_90_C0_33_44_55_66_77_88_99_AA;
    send(4'd7, 16'hA5A5, d, "R8 2/1");
    // R5: negative delta with zero base gives all ones
    d = '0;
    d[64 +: 32] = 32'h00_01_7F_FF;
    send(4'd2, 16'h0000, d, "R5 sign");
    idle(1);

    // R9: inputs change while invalid; output must hold
    @(negedge clk);
    in_valid = 1'b0;
    in_code = 4'd15;
    in_data = {8{32'h0BADF00D}};
    in_mask = 16'hFFFF;
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 outstanding results: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    summary();
  end

endmodule